// File: doc/BRIEF.md
# Processor Debug Event Recorder

This block sits beside a processor pipeline and logs debug-relevant happenings into a sticky status register. It watches six sources:

- a non-critical interrupt being taken;
- a critical interrupt being taken;
- a return-from-interrupt instruction being executed;
- a return-from-critical-interrupt instruction being executed;
- two asynchronous external debug request pins.

Each source has its own enable bit, supplied by a control register outside the block.

An enabled event is always recorded, whatever the global debug-enable bit of the machine state says. When that global bit is set and no higher-priority exception is pending, the block also raises a one-cycle debug interrupt request. Alongside it, the block captures a save address whose source depends on the event type. When a return-type event happens with global debug disabled and external debug mode off, a separate imprecise-event flag is set as well.

Software clears status bits by writing ones. Instruction decode, exception arbitration and interrupt vectoring live elsewhere; their results arrive on the input ports.

Top module: `dbg_event_rec`

## Requirements
- R1: An interrupt-taken pulse with enable bit 0 set sets status bit 0 at the next clock edge; with that enable clear, status bit 0 stays 0.
- R2: A critical-interrupt-taken pulse with enable bit 1 set sets status bit 1, except when the interrupt is itself a debug interrupt while the debug unit is disabled; then nothing is recorded and no request is raised.
- R3: A return (enable bit 2) or critical-return (enable bit 3) execution pulse sets status bit 2 or 3 respectively when its enable is set.
- R4: Recording of any enabled event does not depend on the global debug-enable input or on the higher-priority-pending input.
- R5: Status bit 6 (imprecise flag) is set together with a return or critical-return event when, in the cycle of that event, global debug enable is 0 and external debug mode is 0; otherwise it is left unchanged.
- R6: The debug request `dbg_irq_o` is high for exactly the one cycle after an enabled event whose cycle had global debug enable 1 and no higher-priority exception pending, and is low otherwise. `save_vld_o` is high in exactly the same cycles.
- R7: The save address is the program counter input for return, critical-return and external events, the critical handler address for a critical-interrupt event, and the non-critical handler address for an interrupt event. When several events coincide, the priority is critical-return, return, critical interrupt, interrupt, external 1, external 2.
- R8: External pins 1 and 2 (enable and status bits 4 and 5) pass through a two-flop synchronizer and fire on a rising edge only. The status bit is set at the third clock edge after the pin rises, and a held level produces exactly one event.
- R9: Status bits are sticky. A software write clears exactly the bits written as 1; zeros have no effect; an event setting a bit in the same cycle as its clear leaves the bit at 1.
- R10: During and after reset the status register is 0 and the request, valid strobe and save address are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| evt_en_i | input | 6 | Per-event enable bits (bit order as status bits 0..5) |
| msr_de_i | input | 1 | Global debug enable from machine state (value before any return updates it) |
| edm_i | input | 1 | External debug mode active |
| dbg_unit_en_i | input | 1 | Debug unit enabled |
| hp_pend_i | input | 1 | A higher-priority enabled exception is pending |
| irq_taken_i | input | 1 | Non-critical interrupt taken this cycle |
| irq_addr_i | input | ADDR_W | Non-critical interrupt handler address |
| cirq_taken_i | input | 1 | Critical-class interrupt taken this cycle |
| cirq_is_dbg_i | input | 1 | The critical interrupt taken is a debug interrupt |
| cirq_addr_i | input | ADDR_W | Critical interrupt handler address |
| rfi_exec_i | input | 1 | Return-from-interrupt executed this cycle |
| rfci_exec_i | input | 1 | Return-from-critical-interrupt executed this cycle |
| pc_i | input | ADDR_W | Address of the instruction in this cycle |
| ext_req_i | input | 2 | Asynchronous external debug request pins |
| sw_wr_i | input | 1 | Software write to status register |
| sw_wdata_i | input | 7 | Write-one-to-clear data |
| status_o | output | 7 | Sticky status: bits 0..5 events, bit 6 imprecise flag |
| dbg_irq_o | output | 1 | One-cycle debug interrupt request |
| save_vld_o | output | 1 | Save address valid strobe |
| save_addr_o | output | ADDR_W | Captured debug save address |

## Verification
A software write-one-to-clear and a new event that sets the same status bit can land in the same cycle. The bench provokes this by pulsing the interrupt-taken input in the cycle of a clear of bit 0. It then judges that the bit is still 1 afterwards, and only a later clear with no event removes it. A second case places several pipeline events in the same cycle; the check there is that every status bit is set and that the save address follows the stated priority.

// File: rtl/dbg_rec_pkg.sv
package dbg_rec_pkg;

    localparam int NUM_EVT = 6;
    localparam int STAT_W  = NUM_EVT + 1;
    localparam int NUM_EXT = 2;

    // status / enable bit positions
    localparam int EV_IRQ  = 0;
    localparam int EV_CIRQ = 1;
    localparam int EV_RET  = 2;
    localparam int EV_CRET = 3;
    localparam int EV_EXT1 = 4;
    localparam int EV_EXT2 = 5;
    localparam int IDE_BIT = 6;

    typedef enum logic [1:0] {
        SRC_PC   = 2'd0,
        SRC_IRQ  = 2'd1,
        SRC_CIRQ = 2'd2
    } addr_src_e;

endpackage

// File: rtl/dbg_pin_edge.sv
module dbg_pin_edge #(
    parameter int NUM_PINS = 2,
    parameter int STAGES   = 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_PINS-1:0] pin_i,
    output logic [NUM_PINS-1:0] rise_o
);

    logic [NUM_PINS-1:0][STAGES-1:0] chain_d, chain_q;
    logic [NUM_PINS-1:0]             prev_d, prev_q;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        always_comb begin
            chain_d[p] = {chain_q[p][STAGES-2:0], pin_i[p]};
            prev_d[p]  = chain_q[p][STAGES-1];
            rise_o[p]  = chain_q[p][STAGES-1] & ~prev_q[p];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            chain_q <= '0;
            prev_q  <= '0;
        end else begin
            chain_q <= chain_d;
            prev_q  <= prev_d;
        end
    end

endmodule

// File: rtl/dbg_evt_qual.sv
module dbg_evt_qual
    import dbg_rec_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [NUM_EVT-1:0] evt_en_i,
    input  logic               msr_de_i,
    input  logic               edm_i,
    input  logic               dbg_unit_en_i,
    input  logic               hp_pend_i,
    input  logic               irq_taken_i,
    input  logic               cirq_taken_i,
    input  logic               cirq_is_dbg_i,
    input  logic               rfi_exec_i,
    input  logic               rfci_exec_i,
    input  logic [NUM_EXT-1:0] ext_rise_i,
    input  logic [ADDR_W-1:0]  irq_addr_i,
    input  logic [ADDR_W-1:0]  cirq_addr_i,
    input  logic [ADDR_W-1:0]  pc_i,
    output logic [NUM_EVT-1:0] hit_o,
    output logic               ide_set_o,
    output logic               irq_req_o,
    output logic [ADDR_W-1:0]  addr_o
);

    logic [NUM_EVT-1:0] raw;
    addr_src_e          src;

    always_comb begin
        raw          = '0;
        raw[EV_IRQ]  = irq_taken_i;
        // a debug interrupt with the unit off does not count as critical event
        raw[EV_CIRQ] = cirq_taken_i & ~(cirq_is_dbg_i & ~dbg_unit_en_i);
        raw[EV_RET]  = rfi_exec_i;
        raw[EV_CRET] = rfci_exec_i;
        raw[EV_EXT1] = ext_rise_i[0];
        raw[EV_EXT2] = ext_rise_i[1];

        hit_o     = raw & evt_en_i;
        ide_set_o = (hit_o[EV_RET] | hit_o[EV_CRET]) & ~msr_de_i & ~edm_i;
        irq_req_o = (|hit_o) & msr_de_i & ~hp_pend_i;

        if (hit_o[EV_CRET] || hit_o[EV_RET]) begin
            src = SRC_PC;
        end else if (hit_o[EV_CIRQ]) begin
            src = SRC_CIRQ;
        end else if (hit_o[EV_IRQ]) begin
            src = SRC_IRQ;
        end else begin
            src = SRC_PC;
        end

        unique case (src)
            SRC_IRQ:  addr_o = irq_addr_i;
            SRC_CIRQ: addr_o = cirq_addr_i;
            default:  addr_o = pc_i;
        endcase
    end

endmodule

// File: rtl/dbg_event_rec.sv
module dbg_event_rec
    import dbg_rec_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_EVT-1:0] evt_en_i,
    input  logic               msr_de_i,
    input  logic               edm_i,
    input  logic               dbg_unit_en_i,
    input  logic               hp_pend_i,
    input  logic               irq_taken_i,
    input  logic [ADDR_W-1:0]  irq_addr_i,
    input  logic               cirq_taken_i,
    input  logic               cirq_is_dbg_i,
    input  logic [ADDR_W-1:0]  cirq_addr_i,
    input  logic               rfi_exec_i,
    input  logic               rfci_exec_i,
    input  logic [ADDR_W-1:0]  pc_i,
    input  logic [NUM_EXT-1:0] ext_req_i,
    input  logic               sw_wr_i,
    input  logic [STAT_W-1:0]  sw_wdata_i,
    output logic [STAT_W-1:0]  status_o,
    output logic               dbg_irq_o,
    output logic               save_vld_o,
    output logic [ADDR_W-1:0]  save_addr_o
);

    typedef struct packed {
        logic [STAT_W-1:0] status;
        logic              irq;
        logic              vld;
        logic [ADDR_W-1:0] addr;
    } rec_state_t;

    rec_state_t         st_d, st_q;
    logic [NUM_EXT-1:0] ext_rise;
    logic [NUM_EVT-1:0] hit;
    logic               ide_set;
    logic               irq_req;
    logic [ADDR_W-1:0]  addr_sel;
    logic [STAT_W-1:0]  clr_mask;

    dbg_pin_edge #(
        .NUM_PINS (NUM_EXT),
        .STAGES   (SYNC_STAGES)
    ) i_pin_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  (ext_req_i),
        .rise_o (ext_rise)
    );

    dbg_evt_qual #(
        .ADDR_W (ADDR_W)
    ) i_evt_qual (
        .evt_en_i      (evt_en_i),
        .msr_de_i      (msr_de_i),
        .edm_i         (edm_i),
        .dbg_unit_en_i (dbg_unit_en_i),
        .hp_pend_i     (hp_pend_i),
        .irq_taken_i   (irq_taken_i),
        .cirq_taken_i  (cirq_taken_i),
        .cirq_is_dbg_i (cirq_is_dbg_i),
        .rfi_exec_i    (rfi_exec_i),
        .rfci_exec_i   (rfci_exec_i),
        .ext_rise_i    (ext_rise),
        .irq_addr_i    (irq_addr_i),
        .cirq_addr_i   (cirq_addr_i),
        .pc_i          (pc_i),
        .hit_o         (hit),
        .ide_set_o     (ide_set),
        .irq_req_o     (irq_req),
        .addr_o        (addr_sel)
    );

    always_comb begin
        st_d     = st_q;
        clr_mask = sw_wr_i ? sw_wdata_i : '0;
        // set beats clear
        st_d.status = (st_q.status & ~clr_mask) | {ide_set, hit};
        st_d.irq    = irq_req;
        st_d.vld    = irq_req;
        if (irq_req) begin
            st_d.addr = addr_sel;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o    = st_q.status;
    assign dbg_irq_o   = st_q.irq;
    assign save_vld_o  = st_q.vld;
    assign save_addr_o = st_q.addr;

endmodule

// File: rtl/dbg_event_rec_chk.sv
module dbg_event_rec_chk
    import dbg_rec_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [NUM_EVT-1:0] evt_en_i,
    input logic               msr_de_i,
    input logic               edm_i,
    input logic               hp_pend_i,
    input logic               irq_taken_i,
    input logic               rfi_exec_i,
    input logic [ADDR_W-1:0]  pc_i,
    input logic               sw_wr_i,
    input logic [STAT_W-1:0]  sw_wdata_i,
    input logic [STAT_W-1:0]  status_o,
    input logic               dbg_irq_o,
    input logic               save_vld_o,
    input logic [ADDR_W-1:0]  save_addr_o
);

    logic [STAT_W-1:0] keep;
    assign keep = status_o & ~(sw_wr_i ? sw_wdata_i : '0);

    AST_STICKY_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((status_o & $past(keep)) == $past(keep))); // R9

    AST_IRQ_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_taken_i && evt_en_i[EV_IRQ]) |=> status_o[EV_IRQ]); // R1

    AST_IDE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rfi_exec_i && evt_en_i[EV_RET] && !msr_de_i && !edm_i) |=> status_o[IDE_BIT]); // R5

    AST_IRQ_ONLY_UNMASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dbg_irq_o |-> $past(msr_de_i && !hp_pend_i)); // R6

    AST_IRQ_HAS_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dbg_irq_o |-> save_vld_o); // R6

    AST_RET_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rfi_exec_i && evt_en_i[EV_RET] && msr_de_i && !hp_pend_i)
        |=> (dbg_irq_o && save_addr_o == $past(pc_i))); // R7

endmodule

bind dbg_event_rec dbg_event_rec_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_en_i    (evt_en_i),
    .msr_de_i    (msr_de_i),
    .edm_i       (edm_i),
    .hp_pend_i   (hp_pend_i),
    .irq_taken_i (irq_taken_i),
    .rfi_exec_i  (rfi_exec_i),
    .pc_i        (pc_i),
    .sw_wr_i     (sw_wr_i),
    .sw_wdata_i  (sw_wdata_i),
    .status_o    (status_o),
    .dbg_irq_o   (dbg_irq_o),
    .save_vld_o  (save_vld_o),
    .save_addr_o (save_addr_o)
);

// File: tb/test_dbg_event_rec.sv
`timescale 1ns/1ps
module test_dbg_event_rec;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_ni = 1'b0;
    logic [5:0]    evt_en = '0;
    logic          msr_de = 1'b0, edm = 1'b0, unit_en = 1'b1, hp = 1'b0;
    logic          irq_t = 1'b0, cirq_t = 1'b0, cirq_dbg = 1'b0;
    logic          rfi = 1'b0, rfci = 1'b0;
    logic [AW-1:0] irq_addr = 32'h0000_1000;
    logic [AW-1:0] cirq_addr = 32'h0000_2000;
    logic [AW-1:0] pc = 32'h0000_3000;
    logic [1:0]    ext = '0;
    logic          sw_wr = 1'b0;
    logic [6:0]    sw_wdata = '0;
    logic [6:0]    status;
    logic          dbg_irq, save_vld;
    logic [AW-1:0] save_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dbg_event_rec #(.ADDR_W(AW), .SYNC_STAGES(2)) i_dbg_event_rec (
        .clk_i(clk), .rst_ni(rst_ni), .evt_en_i(evt_en), .msr_de_i(msr_de),
        .edm_i(edm), .dbg_unit_en_i(unit_en), .hp_pend_i(hp),
        .irq_taken_i(irq_t), .irq_addr_i(irq_addr), .cirq_taken_i(cirq_t),
        .cirq_is_dbg_i(cirq_dbg), .cirq_addr_i(cirq_addr), .rfi_exec_i(rfi),
        .rfci_exec_i(rfci), .pc_i(pc), .ext_req_i(ext), .sw_wr_i(sw_wr),
        .sw_wdata_i(sw_wdata), .status_o(status), .dbg_irq_o(dbg_irq),
        .save_vld_o(save_vld), .save_addr_o(save_addr)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_all();
        irq_t = 0; cirq_t = 0; rfi = 0; rfci = 0;
        sw_wr = 1; sw_wdata = 7'h7F;
        tick();
        sw_wr = 0; sw_wdata = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [6:0]    exp_st;
        logic          exp_irq;
        logic [AW-1:0] exp_addr;
        int            pulses;

        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 status", status, 0);
        chk("R10 irq", dbg_irq, 0);
        chk("R10 vld", save_vld, 0);
        chk("R10 addr", save_addr, 0);
        rst_ni = 1;
        tick();

        // sweep: event type x enable x de x edm x hp  (R1 R3 R4 R5 R6 R7)
        for (int ev = 0; ev < 4; ev++) begin
            for (int c = 0; c < 16; c++) begin
                logic en;
                en     = c[0];
                msr_de = c[1];
                edm    = c[2];
                hp     = c[3];
                pc     = 32'h0000_3000 + (ev * 16 + c) * 4;
                evt_en = en ? 6'h3F : (6'h3F & ~(6'd1 << ev));
                irq_t  = (ev == 0);
                cirq_t = (ev == 1);
                rfi    = (ev == 2);
                rfci   = (ev == 3);
                tick();
                exp_st = 7'(en) << ev;
                if (en && ev >= 2 && !msr_de && !edm) exp_st[6] = 1'b1;
                exp_irq  = en && msr_de && !hp;
                exp_addr = (ev == 0) ? irq_addr : (ev == 1) ? cirq_addr : pc;
                chk($sformatf("R1/R3/R4/R5 status ev%0d c%0d", ev, c), status, exp_st);
                chk($sformatf("R6 irq ev%0d c%0d", ev, c), dbg_irq, exp_irq);
                chk($sformatf("R6 vld ev%0d c%0d", ev, c), save_vld, exp_irq);
                if (exp_irq) chk($sformatf("R7 addr ev%0d c%0d", ev, c), save_addr, exp_addr);
                clear_all();
                chk("R6 pulse ends", dbg_irq, 0);
            end
        end
        hp = 0; edm = 0;

        // R2: debug-class critical interrupt with unit disabled
        evt_en = 6'h3F; msr_de = 1; unit_en = 0; cirq_t = 1; cirq_dbg = 1;
        tick();
        chk("R2 dbg cirq unit off status", status, 0);
        chk("R2 dbg cirq unit off irq", dbg_irq, 0);
        unit_en = 1;
        tick();
        chk("R2 dbg cirq unit on status", status, 7'h02);
        chk("R2 dbg cirq unit on addr", save_addr, cirq_addr);
        cirq_dbg = 0;
        clear_all();

        // R7: priority among coincident events
        pc = 32'h0000_4440;
        irq_t = 1; cirq_t = 1; rfi = 1;
        tick();
        chk("R7 prio status", status, 7'h07);
        chk("R7 prio ret over handlers", save_addr, pc);
        irq_t = 1; cirq_t = 1; rfi = 0;
        tick();
        chk("R7 prio cirq over irq", save_addr, cirq_addr);
        clear_all();

        // R8: external pin 1, synchronized rising edge, held level
        pc = 32'h0000_5550;
        ext[0] = 1;
        tick();
        chk("R8 ext1 edge1", status[4], 0);
        tick();
        chk("R8 ext1 edge2", status[4], 0);
        tick();
        chk("R8 ext1 edge3", status[4], 1);
        chk("R8 ext1 irq", dbg_irq, 1);
        chk("R7 ext1 addr", save_addr, pc);
        pulses = 0;
        for (int k = 0; k < 10; k++) begin
            tick();
            if (dbg_irq) pulses++;
        end
        chk("R8 held level one event", pulses, 0);
        ext[0] = 0;
        repeat (3) tick();
        clear_all();
        chk("R8 cleared", status, 0);

        // R8: external pin 2 disabled then enabled
        evt_en = 6'h1F; ext[1] = 1;
        repeat (5) tick();
        chk("R8 ext2 disabled", status, 0);
        ext[1] = 0;
        repeat (3) tick();
        evt_en = 6'h3F; ext[1] = 1;
        repeat (3) tick();
        chk("R8 ext2 enabled", status, 7'h20);
        ext[1] = 0;
        repeat (3) tick();
        clear_all();

        // R9: sticky, zero writes, set beats clear
        msr_de = 0;
        irq_t = 1;
        tick();
        irq_t = 0;
        chk("R9 set", status, 7'h01);
        sw_wr = 1; sw_wdata = 7'h00;
        tick();
        chk("R9 zero write no effect", status, 7'h01);
        sw_wdata = 7'h01; irq_t = 1;
        tick();
        irq_t = 0;
        chk("R9 set wins over clear", status, 7'h01);
        tick();
        chk("R9 clear", status, 7'h00);
        sw_wr = 0; sw_wdata = '0;
        tick();
        chk("R9 stays clear", status, 7'h00);

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule